// File: doc/BRIEF.md
# Channel Status and Interrupt Unit

This block holds the event status of one channel of a serial media bus and turns it into a single interrupt line. The channel datapath reports what happens through strobes and levels: push and pop attempts with the buffer's full and empty flags, pulses when a buffer transfer starts or completes, received command or response bytes, and the fill level of the local buffer. Each reportable event is latched into a sticky status bit that holds until software writes a one to it.

Two status bits change meaning with the operating mode. With DMA transfers, they record buffer start and buffer completion. With programmed I/O, they become service requests. These are raised when the fill level (transmit) or the free space (receive) falls to a programmed 7-bit threshold or below. Some events are accepted only for certain channel types. A per-bit mask selects which status bits drive the interrupt, and the interrupt is registered.

A small register port gives access to two locations: the status word (read, write-one-to-clear) and the interrupt mask (read/write).

Top module: `chan_stat_unit`

## Requirements
- R1: After reset the status word, the mask and the interrupt output are all zero.
- R2: Status bit 4 (buffer error) sets when a transmit channel (`cfg_dir_tx`=1) asserts `pop_try` while `buf_empty` is high, or when a receive channel asserts `push_try` while `buf_full` is high; an attempt on a non-empty or non-full buffer sets nothing.
- R3: Bit 4 can only be set on a synchronous channel (`cfg_type`=2'b00) of either direction, or on an isochronous receive channel (`cfg_type`=2'b01, `cfg_dir_tx`=0) with `cfg_fce`=0; on any other combination the error event is ignored.
- R4: Status bits are sticky. Writing a 1 at address 0 clears that bit; writing a 0 leaves it unchanged.
- R5: When a hardware set and a software clear reach the same bit in the same cycle, the bit ends up set.
- R6: With `cfg_io_mode`=0, a `buf_start` pulse sets bit 3 and a `buf_done` pulse sets bit 2; with `cfg_io_mode`=1 these pulses are ignored.
- R7: With `cfg_io_mode`=1 on a transmit channel, bit 3 sets in the cycle where `fill_cnt` <= `thresh` becomes true; a condition that stays true does not set it again by itself.
- R8: With `cfg_io_mode`=1 on a receive channel, bit 2 sets in the cycle where the free space (BUF_QUADS - `fill_cnt`, 64 by default) <= `thresh` becomes true.
- R9: If software clears a service-request bit while its condition still holds, the bit reads 0 for one cycle and then sets again.
- R10: Bit 1 (break) sets on `cmd_vld` only for asynchronous (2'b10) or control (2'b11) channels: a transmit channel matching byte 8'h70, a receive channel matching 8'h36 or 8'h26.
- R11: `irq` goes high one cycle after a status bit whose mask bit (address 1) is 1 is set, and stays low for set bits whose mask bit is 0.
- R12: `rd_data` returns the status word when `reg_addr`=0 and the mask when `reg_addr`=1; bit 0 of both is reserved and always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_io_mode | input | 1 | 1 = programmed I/O mode, 0 = DMA mode |
| cfg_type | input | 2 | Channel type: 00 sync, 01 isochronous, 10 async, 11 control |
| cfg_dir_tx | input | 1 | 1 = transmit channel, 0 = receive channel |
| cfg_fce | input | 1 | Flow control enable (isochronous) |
| thresh | input | 7 | Service threshold in quadlets |
| fill_cnt | input | 7 | Valid quadlets in the local buffer |
| push_try | input | 1 | Datapath attempts a push |
| pop_try | input | 1 | Datapath attempts a pop |
| buf_full | input | 1 | Local buffer full |
| buf_empty | input | 1 | Local buffer empty |
| buf_start | input | 1 | DMA current buffer started pulse |
| buf_done | input | 1 | DMA current buffer completed pulse |
| cmd_vld | input | 1 | Command/response byte valid |
| cmd_byte | input | 8 | Received command/response byte |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = status, 1 = mask |
| reg_wdata | input | 5 | Register write data |
| rd_data | output | 5 | Register read data |
| status_o | output | 5 | Status word |
| irq | output | 1 | Registered channel interrupt |

## Verification
The hardest case is the re-arm of a level-based service request. Software must clear the bit while the fill-level condition is still true, and the bit must come back exactly one cycle later. The bench holds `fill_cnt` at the threshold in I/O mode and issues the clear. It then samples the status in the cycle straight after the write, where it should read 0, and in the following cycle, where it should read 1. It then moves the fill level away, clears again, and shows that the bit stays clear until the condition becomes true once more. A second awkward case is a set colliding with a clear. The bench produces it by raising an underflow attempt in the same cycle as the write-one-to-clear of that bit.

// File: rtl/chan_stat_pkg.sv
package chan_stat_pkg;

  typedef enum logic [1:0] {
    CH_SYNC  = 2'b00,
    CH_ISOC  = 2'b01,
    CH_ASYNC = 2'b10,
    CH_CTRL  = 2'b11
  } ch_type_e;

  localparam int STAT_W  = 5;
  localparam int B_ERR   = 4;
  localparam int B_START = 3;
  localparam int B_DONE  = 2;
  localparam int B_BRK   = 1;

  // bits that hold state; bit 0 is reserved
  localparam logic [STAT_W-1:0] LIVE_BITS = 5'b11110;

  localparam logic [7:0] BRK_TX_RESP = 8'h70;
  localparam logic [7:0] BRK_RX_CMD0 = 8'h36;
  localparam logic [7:0] BRK_RX_CMD1 = 8'h26;

endpackage

// File: rtl/chan_stat_evt.sv
module chan_stat_evt
  import chan_stat_pkg::*;
#(
  parameter int BUF_QUADS = 64,
  parameter int TH_W      = 7,
  parameter int CNT_W     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_io_mode,
  input  logic [1:0]        cfg_type,
  input  logic              cfg_dir_tx,
  input  logic              cfg_fce,
  input  logic [TH_W-1:0]   thresh,
  input  logic [CNT_W-1:0]  fill_cnt,
  input  logic              push_try,
  input  logic              pop_try,
  input  logic              buf_full,
  input  logic              buf_empty,
  input  logic              buf_start,
  input  logic              buf_done,
  input  logic              cmd_vld,
  input  logic [7:0]        cmd_byte,
  input  logic              clr_start,
  input  logic              clr_done,
  output logic [STAT_W-1:0] set_vec
);

  localparam int CMP_W = ((CNT_W > TH_W) ? CNT_W : TH_W) + 1;

  ch_type_e         typ;
  logic [CMP_W-1:0] fill_x, free_x, th_x;
  logic             err_ok, brk_ok, brk_hit, err_hit;
  logic             tx_cond, rx_cond;
  logic             tx_cond_q, rx_cond_q, tx_clr_q, rx_clr_q;

  always_comb begin
    typ     = ch_type_e'(cfg_type);
    fill_x  = CMP_W'(fill_cnt);
    free_x  = CMP_W'(BUF_QUADS) - fill_x;
    th_x    = CMP_W'(thresh);

    err_ok  = (typ == CH_SYNC) ||
              ((typ == CH_ISOC) && !cfg_dir_tx && !cfg_fce);
    err_hit = cfg_dir_tx ? (pop_try & buf_empty) : (push_try & buf_full);

    brk_ok  = (typ == CH_ASYNC) || (typ == CH_CTRL);
    brk_hit = cfg_dir_tx ? (cmd_byte == BRK_TX_RESP)
                         : ((cmd_byte == BRK_RX_CMD0) || (cmd_byte == BRK_RX_CMD1));

    tx_cond = cfg_io_mode &  cfg_dir_tx & (fill_x <= th_x);
    rx_cond = cfg_io_mode & ~cfg_dir_tx & (free_x <= th_x);

    set_vec          = '0;
    set_vec[B_ERR]   = err_ok & err_hit;
    set_vec[B_START] = cfg_io_mode ? (tx_cond & (~tx_cond_q | tx_clr_q)) : buf_start;
    set_vec[B_DONE]  = cfg_io_mode ? (rx_cond & (~rx_cond_q | rx_clr_q)) : buf_done;
    set_vec[B_BRK]   = brk_ok & cmd_vld & brk_hit;
  end

  // condition history and clear history for edge qualification
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_cond_q <= 1'b0;
      rx_cond_q <= 1'b0;
      tx_clr_q  <= 1'b0;
      rx_clr_q  <= 1'b0;
    end else begin
      tx_cond_q <= tx_cond;
      rx_cond_q <= rx_cond;
      tx_clr_q  <= clr_start;
      rx_clr_q  <= clr_done;
    end
  end

endmodule

// File: rtl/chan_stat_reg.sv
module chan_stat_reg
  import chan_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_vec,
  input  logic [STAT_W-1:0] clr_vec,
  output logic [STAT_W-1:0] status_q
);

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (LIVE_BITS[i]) begin : g_live
      logic bit_q, bit_d, bit_en;

      always_comb begin
        bit_en = set_vec[i] | clr_vec[i];
        bit_d  = set_vec[i] | (bit_q & ~clr_vec[i]);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bit_q <= 1'b0;
        end else if (bit_en) begin
          bit_q <= bit_d;
        end
      end

      assign status_q[i] = bit_q;
    end else begin : g_rsvd
      logic unused_b;
      assign unused_b    = set_vec[i] ^ clr_vec[i];
      assign status_q[i] = 1'b0;
    end
  end

endmodule

// File: rtl/chan_stat_bus.sv
module chan_stat_bus
  import chan_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [STAT_W-1:0] reg_wdata,
  input  logic [STAT_W-1:0] status_q,
  output logic [STAT_W-1:0] clr_vec,
  output logic [STAT_W-1:0] mask_q,
  output logic [STAT_W-1:0] rd_data
);

  logic              mask_en;
  logic [STAT_W-1:0] mask_d;

  always_comb begin
    clr_vec = (reg_wr && !reg_addr) ? (reg_wdata & LIVE_BITS) : '0;
    mask_en = reg_wr && reg_addr;
    mask_d  = reg_wdata & LIVE_BITS;
    rd_data = reg_addr ? mask_q : status_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

endmodule

// File: rtl/chan_stat_irq.sv
module chan_stat_irq
  import chan_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] status_q,
  input  logic [STAT_W-1:0] mask_q,
  output logic              irq_q
);

  logic irq_d;

  always_comb begin
    irq_d = |(status_q & mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

endmodule

// File: rtl/chan_stat_unit.sv
module chan_stat_unit
  import chan_stat_pkg::*;
#(
  parameter int BUF_QUADS = 64,
  parameter int TH_W      = 7,
  localparam int CNT_W    = $clog2(BUF_QUADS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_io_mode,
  input  logic [1:0]        cfg_type,
  input  logic              cfg_dir_tx,
  input  logic              cfg_fce,
  input  logic [TH_W-1:0]   thresh,
  input  logic [CNT_W-1:0]  fill_cnt,
  input  logic              push_try,
  input  logic              pop_try,
  input  logic              buf_full,
  input  logic              buf_empty,
  input  logic              buf_start,
  input  logic              buf_done,
  input  logic              cmd_vld,
  input  logic [7:0]        cmd_byte,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [STAT_W-1:0] rd_data,
  output logic [STAT_W-1:0] status_o,
  output logic              irq
);

  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] status_q;
  logic [STAT_W-1:0] mask_q;

  chan_stat_evt #(
    .BUF_QUADS (BUF_QUADS),
    .TH_W      (TH_W),
    .CNT_W     (CNT_W)
  ) u_evt (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_io_mode (cfg_io_mode),
    .cfg_type    (cfg_type),
    .cfg_dir_tx  (cfg_dir_tx),
    .cfg_fce     (cfg_fce),
    .thresh      (thresh),
    .fill_cnt    (fill_cnt),
    .push_try    (push_try),
    .pop_try     (pop_try),
    .buf_full    (buf_full),
    .buf_empty   (buf_empty),
    .buf_start   (buf_start),
    .buf_done    (buf_done),
    .cmd_vld     (cmd_vld),
    .cmd_byte    (cmd_byte),
    .clr_start   (clr_vec[B_START]),
    .clr_done    (clr_vec[B_DONE]),
    .set_vec     (set_vec)
  );

  chan_stat_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .status_q (status_q)
  );

  chan_stat_bus u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .status_q  (status_q),
    .clr_vec   (clr_vec),
    .mask_q    (mask_q),
    .rd_data   (rd_data)
  );

  chan_stat_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_q (status_q),
    .mask_q   (mask_q),
    .irq_q    (irq)
  );

  assign status_o = status_q;

endmodule

// File: rtl/chan_stat_chk.sv
module chan_stat_chk
  import chan_stat_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cfg_type,
  input logic              cfg_dir_tx,
  input logic              cfg_fce,
  input logic [STAT_W-1:0] set_vec,
  input logic [STAT_W-1:0] clr_vec,
  input logic [STAT_W-1:0] status_q,
  input logic [STAT_W-1:0] mask_q,
  input logic              irq
);

  // R4: set bits not being cleared stay set
  a_r4_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(status_q & ~clr_vec)) == $past(status_q & ~clr_vec)));

  // R4: a clear without a competing set leaves the bit low
  a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(clr_vec & ~set_vec)) == '0));

  // R5: every hardware set lands, whatever software writes
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  // R3: error event only on qualifying channel types
  a_r3_err_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[B_ERR] |-> ((cfg_type == 2'b00) ||
                        ((cfg_type == 2'b01) && !cfg_dir_tx && !cfg_fce)));

  // R10: break only on async or control channels
  a_r10_brk_type: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[B_BRK] |-> cfg_type[1]);

  // R11: interrupt follows masked status one cycle later
  a_r11_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(status_q & mask_q))));

endmodule

bind chan_stat_unit chan_stat_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_type   (cfg_type),
  .cfg_dir_tx (cfg_dir_tx),
  .cfg_fce    (cfg_fce),
  .set_vec    (set_vec),
  .clr_vec    (clr_vec),
  .status_q   (status_q),
  .mask_q     (mask_q),
  .irq        (irq)
);

// File: tb/chan_stat_unit_tb.sv
`timescale 1ns/1ps
module chan_stat_unit_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_io_mode, cfg_dir_tx, cfg_fce;
  logic [1:0] cfg_type;
  logic [6:0] thresh, fill_cnt;
  logic       push_try, pop_try, buf_full, buf_empty, buf_start, buf_done;
  logic       cmd_vld;
  logic [7:0] cmd_byte;
  logic       reg_wr, reg_addr;
  logic [4:0] reg_wdata, rd_data, status_o;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  chan_stat_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_io_mode(cfg_io_mode), .cfg_type(cfg_type),
    .cfg_dir_tx(cfg_dir_tx), .cfg_fce(cfg_fce), .thresh(thresh), .fill_cnt(fill_cnt),
    .push_try(push_try), .pop_try(pop_try), .buf_full(buf_full), .buf_empty(buf_empty),
    .buf_start(buf_start), .buf_done(buf_done), .cmd_vld(cmd_vld), .cmd_byte(cmd_byte),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rd_data(rd_data), .status_o(status_o), .irq(irq)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic a, input logic [4:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
  endtask

  task automatic clear_all();
    wr_reg(1'b0, 5'h1F);
    chk("R4 clear all", status_o, 5'h00);
  endtask

  task automatic underflow();
    pop_try = 1'b1; buf_empty = 1'b1;
    step();
    pop_try = 1'b0; buf_empty = 1'b0;
  endtask

  task automatic overflow();
    push_try = 1'b1; buf_full = 1'b1;
    step();
    push_try = 1'b0; buf_full = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] b);
    cmd_vld = 1'b1; cmd_byte = b;
    step();
    cmd_vld = 1'b0; cmd_byte = '0;
  endtask

  task automatic t_reset();
    chk("R1 status", status_o, 5'h00);
    chk("R1 irq", irq, 1'b0);
    reg_addr = 1'b1;
    #0.1;
    chk("R1 mask", rd_data, 5'h00);
    reg_addr = 1'b0;
  endtask

  task automatic t_buf_err();
    cfg_type = 2'b00; cfg_dir_tx = 1'b1;
    pop_try = 1'b1; buf_empty = 1'b0;
    step(); pop_try = 1'b0;
    chk("R2 pop non-empty", status_o, 5'h00);
    underflow();
    chk("R2 tx underflow", status_o, 5'h10);
    wr_reg(1'b0, 5'h00);
    chk("R4 write zero keeps", status_o, 5'h10);
    step();
    chk("R4 holds", status_o, 5'h10);
    wr_reg(1'b0, 5'h10);
    chk("R4 w1c", status_o, 5'h00);
    cfg_dir_tx = 1'b0;
    overflow();
    chk("R2 rx overflow", status_o, 5'h10);
    clear_all();
  endtask

  task automatic t_err_qual();
    cfg_type = 2'b10; cfg_dir_tx = 1'b1;
    underflow();
    chk("R3 async ignored", status_o, 5'h00);
    cfg_type = 2'b01; cfg_dir_tx = 1'b1;
    underflow();
    chk("R3 isoc tx ignored", status_o, 5'h00);
    cfg_dir_tx = 1'b0; cfg_fce = 1'b1;
    overflow();
    chk("R3 isoc fce ignored", status_o, 5'h00);
    cfg_fce = 1'b0;
    overflow();
    chk("R3 isoc rx accepted", status_o, 5'h10);
    clear_all();
    cfg_type = 2'b00;
  endtask

  task automatic t_set_wins();
    cfg_dir_tx = 1'b1;
    underflow();
    reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 5'h10;
    pop_try = 1'b1; buf_empty = 1'b1;
    step();
    reg_wr = 1'b0; reg_wdata = '0; pop_try = 1'b0; buf_empty = 1'b0;
    chk("R5 set beats clear", status_o, 5'h10);
    clear_all();
  endtask

  task automatic t_dma();
    buf_start = 1'b1; step(); buf_start = 1'b0;
    chk("R6 start", status_o, 5'h08);
    buf_done = 1'b1; step(); buf_done = 1'b0;
    chk("R6 done", status_o, 5'h0C);
    clear_all();
  endtask

  task automatic t_io_tx();
    cfg_dir_tx = 1'b1; thresh = 7'd10; fill_cnt = 7'd20;
    cfg_io_mode = 1'b1;
    step();
    chk("R7 above threshold", status_o, 5'h00);
    buf_start = 1'b1; buf_done = 1'b1; step(); buf_start = 1'b0; buf_done = 1'b0;
    chk("R6 pulses ignored in io", status_o, 5'h00);
    fill_cnt = 7'd11; step();
    chk("R7 one above", status_o, 5'h00);
    fill_cnt = 7'd10; step();
    chk("R7 at threshold", status_o, 5'h08);
    wr_reg(1'b0, 5'h08);
    chk("R9 low after clear", status_o, 5'h00);
    step();
    chk("R9 re-sets", status_o, 5'h08);
    fill_cnt = 7'd20; step();
    wr_reg(1'b0, 5'h08);
    step(); step();
    chk("R7 no set when false", status_o, 5'h00);
    fill_cnt = 7'd3; step();
    chk("R7 rises again", status_o, 5'h08);
    fill_cnt = 7'd20; step();
    clear_all();
    cfg_io_mode = 1'b0;
  endtask

  task automatic t_io_rx();
    cfg_dir_tx = 1'b0; thresh = 7'd4; fill_cnt = 7'd50;
    cfg_io_mode = 1'b1;
    step();
    chk("R8 free 14", status_o, 5'h00);
    fill_cnt = 7'd60; step();
    chk("R8 free 4", status_o, 5'h04);
    fill_cnt = 7'd50; step();
    clear_all();
    step();
    chk("R8 stays clear", status_o, 5'h00);
    cfg_io_mode = 1'b0; fill_cnt = 7'd0; thresh = 7'd0;
  endtask

  task automatic t_break();
    cfg_type = 2'b11; cfg_dir_tx = 1'b1;
    send_cmd(8'h36);
    chk("R10 tx wrong byte", status_o, 5'h00);
    send_cmd(8'h70);
    chk("R10 ctrl tx 70", status_o, 5'h02);
    clear_all();
    cfg_type = 2'b10; cfg_dir_tx = 1'b0;
    send_cmd(8'h36);
    chk("R10 async rx 36", status_o, 5'h02);
    clear_all();
    send_cmd(8'h26);
    chk("R10 async rx 26", status_o, 5'h02);
    clear_all();
    cfg_type = 2'b00;
    send_cmd(8'h36);
    chk("R10 sync ignored", status_o, 5'h00);
  endtask

  task automatic t_irq();
    wr_reg(1'b1, 5'h1F);
    reg_addr = 1'b1; #0.1;
    chk("R12 mask readback", rd_data, 5'h1E);
    reg_addr = 1'b0;
    wr_reg(1'b1, 5'h10);
    cfg_type = 2'b00; cfg_dir_tx = 1'b1;
    pop_try = 1'b1; buf_empty = 1'b1;
    step();
    pop_try = 1'b0; buf_empty = 1'b0;
    chk("R11 irq not yet", irq, 1'b0);
    step();
    chk("R11 irq high", irq, 1'b1);
    clear_all();
    step();
    chk("R11 irq drops", irq, 1'b0);
    cfg_type = 2'b11;
    send_cmd(8'h70);
    step();
    chk("R11 masked bit", irq, 1'b0);
    #0.1;
    chk("R12 status read", rd_data, 5'h02);
    wr_reg(1'b0, 5'h01);
    chk("R12 reserved bit", status_o, 5'h02);
    clear_all();
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_io_mode = 1'b0; cfg_type = 2'b00; cfg_dir_tx = 1'b1; cfg_fce = 1'b0;
    thresh = '0; fill_cnt = '0;
    push_try = 1'b0; pop_try = 1'b0; buf_full = 1'b0; buf_empty = 1'b0;
    buf_start = 1'b0; buf_done = 1'b0; cmd_vld = 1'b0; cmd_byte = '0;
    reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_buf_err();
    t_err_qual();
    t_set_wins();
    t_dma();
    t_io_tx();
    t_io_rx();
    t_break();
    t_irq();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule